// File: doc/BRIEF.md
# Interrupt Cause Bank

This block gathers up to 32 single-cycle hardware event pulses into a sticky cause register. It drives one level-sensitive pending line that a host interrupt controller or a higher-level aggregator can watch. Each source has a mask bit. A masked source still records its event, and the mask only decides whether that event reaches the pending line.

The host reaches the bank through a simple word-addressed register port, and read data appears one cycle after the read strobe. Write-only offsets do three jobs: they raise mask bits, lower mask bits, and force cause bits so that software can raise its own interrupt. A per-bit clear-mode register picks how each cause bit is retired:
- A bit in clear-on-read mode is cleared by a read of the cause offset.
- A bit in write-one-to-clear mode is cleared by writing a one to it at the cause offset.

The host therefore acknowledges write-one-to-clear bits by writing back the value it just read. Two read-only views are also provided: the mask, and the cause after masking.

Top module: `irq_cause_bank`

## Requirements
- R1: A pulse on `evt_i[n]` sets cause bit n at the next clock edge whether or not bit n is masked. The bit then stays set until a clear rule removes it.
- R2: `irq_pending_o` is a registered output. After every clock edge it equals the OR of (cause AND NOT mask) for the state held after that edge.
- R3: A write to offset 2 (mask-set) with data D ORs D into the mask register. D = all ones masks every source.
- R4: A write to offset 3 (mask-clear) with data D clears the mask bits where D is one, which unmasks those sources.
- R5: A write to offset 1 (cause-force) with data D sets every cause bit where D is one.
- R6: A write to offset 0 (cause) with data D clears the cause bits where D is one and the clear-mode bit is 0. Cause bits whose clear-mode bit is 1 ignore the write.
- R7: A read of offset 0 returns the cause value from before the edge. It clears exactly the cause bits whose clear-mode bit is 1, and leaves bits in mode 0 unchanged.
- R8: Offset 6 is the read/write clear-mode register: bit value 1 selects clear-on-read and 0 selects write-one-to-clear.
- R9: When an event (or a force) for a bit falls in the same cycle as a clear of that bit, by read or by write, the bit stays set.
- R10: Synchronous reset clears all cause bits, sets every mask bit, clears the clear-mode register and drives `irq_pending_o` low.
- R11: Offsets 7 and above read as zero, ignore writes and change no state.
- R12: Offset 4 reads the mask and offset 5 reads cause AND NOT mask. Both are read-only: writes to them are ignored, and reading them clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | WIDTH | Event pulses, one per source |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | ADDR_W | Word offset |
| wdata_i | input | WIDTH | Host write data |
| rdata_o | output | WIDTH | Read data, valid the cycle after `rd_en_i` |
| irq_pending_o | output | 1 | High while any unmasked cause bit is set |

## Verification
An event pulse can land on a bit in the same cycle that the host clears that bit. The clear can be a write of one in write-one-to-clear mode, or a read of the cause offset in clear-on-read mode. The bench drives the event and the clearing access on the same clock edge for both modes. It then reads the cause back, and expects the bit still set and the pending line still high. For the read case it also expects the returned value to show the bit as it stood before that edge.

// File: rtl/icb_pkg.sv
package icb_pkg;

  // Word offsets of the host register port
  localparam int OFS_CAUSE  = 0;  // read: raw cause (clear-on-read bits drop); write: W1C
  localparam int OFS_FORCE  = 1;  // write: force cause bits
  localparam int OFS_MSET   = 2;  // write: set mask bits
  localparam int OFS_MCLR   = 3;  // write: clear mask bits
  localparam int OFS_MASK   = 4;  // read: mask view
  localparam int OFS_MASKED = 5;  // read: cause & ~mask
  localparam int OFS_MODE   = 6;  // read/write: clear-mode, 1 = clear-on-read

  typedef enum logic [2:0] {
    RS_ZERO,
    RS_CAUSE,
    RS_MASK,
    RS_MASKED,
    RS_MODE
  } rsel_t;

  typedef struct packed {
    logic cause_w1c;
    logic force_set;
    logic mask_set;
    logic mask_clr;
    logic mode_wr;
    logic cause_rd;
  } strobe_t;

endpackage

// File: rtl/icb_decode.sv
module icb_decode
  import icb_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output strobe_t           stb_o,
  output rsel_t             rsel_o
);

  always_comb begin
    stb_o           = '0;
    stb_o.cause_w1c = wr_en_i && (addr_i == ADDR_W'(OFS_CAUSE));
    stb_o.force_set = wr_en_i && (addr_i == ADDR_W'(OFS_FORCE));
    stb_o.mask_set  = wr_en_i && (addr_i == ADDR_W'(OFS_MSET));
    stb_o.mask_clr  = wr_en_i && (addr_i == ADDR_W'(OFS_MCLR));
    stb_o.mode_wr   = wr_en_i && (addr_i == ADDR_W'(OFS_MODE));
    stb_o.cause_rd  = rd_en_i && (addr_i == ADDR_W'(OFS_CAUSE));
  end

  always_comb begin
    if (addr_i == ADDR_W'(OFS_CAUSE))       rsel_o = RS_CAUSE;
    else if (addr_i == ADDR_W'(OFS_MASK))   rsel_o = RS_MASK;
    else if (addr_i == ADDR_W'(OFS_MASKED)) rsel_o = RS_MASKED;
    else if (addr_i == ADDR_W'(OFS_MODE))   rsel_o = RS_MODE;
    else                                    rsel_o = RS_ZERO;
  end

endmodule

// File: rtl/icb_cause_reg.sv
module icb_cause_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] evt_i,
  input  logic [WIDTH-1:0] mode_i,
  input  logic             force_en_i,
  input  logic             w1c_en_i,
  input  logic             cor_en_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] cause_d_o,
  output logic [WIDTH-1:0] cause_q_o
);

  logic [WIDTH-1:0] cause_q;

  // One slice per source: set terms win over clear terms
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic clr_bit;
    logic set_bit;
    always_comb begin
      clr_bit      = (w1c_en_i && wdata_i[i] && !mode_i[i]) || (cor_en_i && mode_i[i]);
      set_bit      = evt_i[i] || (force_en_i && wdata_i[i]);
      cause_d_o[i] = (cause_q[i] && !clr_bit) || set_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= cause_d_o;
  end

  assign cause_q_o = cause_q;

endmodule

// File: rtl/icb_ctrl_reg.sv
module icb_ctrl_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_set_i,
  input  logic             mask_clr_i,
  input  logic             mode_wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] mask_d_o,
  output logic [WIDTH-1:0] mask_q_o,
  output logic [WIDTH-1:0] mode_q_o
);

  always_comb begin
    mask_d_o = mask_q_o;
    if (mask_set_i) mask_d_o = mask_q_o | wdata_i;
    if (mask_clr_i) mask_d_o = mask_q_o & ~wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q_o <= '1;
      mode_q_o <= '0;
    end else begin
      mask_q_o <= mask_d_o;
      if (mode_wr_i) mode_q_o <= wdata_i;
    end
  end

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import icb_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic              irq_pending_o
);

  strobe_t          stb;
  rsel_t            rsel;
  logic [WIDTH-1:0] cause_d, cause_q;
  logic [WIDTH-1:0] mask_d, mask_q, mode_q;

  icb_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .stb_o   (stb),
    .rsel_o  (rsel)
  );

  icb_cause_reg #(.WIDTH(WIDTH)) u_cause (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt_i),
    .mode_i     (mode_q),
    .force_en_i (stb.force_set),
    .w1c_en_i   (stb.cause_w1c),
    .cor_en_i   (stb.cause_rd),
    .wdata_i    (wdata_i),
    .cause_d_o  (cause_d),
    .cause_q_o  (cause_q)
  );

  icb_ctrl_reg #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .mask_set_i (stb.mask_set),
    .mask_clr_i (stb.mask_clr),
    .mode_wr_i  (stb.mode_wr),
    .wdata_i    (wdata_i),
    .mask_d_o   (mask_d),
    .mask_q_o   (mask_q),
    .mode_q_o   (mode_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_en_i) begin
      case (rsel)
        RS_CAUSE:  rdata_o <= cause_q;
        RS_MASK:   rdata_o <= mask_q;
        RS_MASKED: rdata_o <= cause_q & ~mask_q;
        RS_MODE:   rdata_o <= mode_q;
        default:   rdata_o <= '0;
      endcase
    end else begin
      rdata_o <= '0;
    end
  end

  // Pending is registered from next-state values so it tracks the stored state
  always_ff @(posedge clk) begin
    if (rst) irq_pending_o <= 1'b0;
    else     irq_pending_o <= |(cause_d & ~mask_d);
  end

endmodule

// File: rtl/icb_checker.sv
module icb_checker #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [WIDTH-1:0]  evt_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  rdata_o,
  input logic              irq_pending_o,
  input logic [WIDTH-1:0]  cause_q,
  input logic [WIDTH-1:0]  mask_q,
  input logic [WIDTH-1:0]  mode_q
);

  a_r1_event_latches: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

  a_r2_pending_level: assert property (@(posedge clk) disable iff (rst)
    irq_pending_o == |(cause_q & ~mask_q));

  a_r3_mask_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == ADDR_W'(2)) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  a_r4_mask_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == ADDR_W'(3)) |=> ((mask_q & $past(wdata_i)) == '0));

  a_r5_force: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == ADDR_W'(1)) |=> ((cause_q & $past(wdata_i)) == $past(wdata_i)));

  a_r7_clear_on_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == ADDR_W'(0) && !wr_en_i && evt_i == '0)
      |=> ((cause_q & $past(mode_q)) == '0));

  a_r10_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1 && cause_q == '0 && mode_q == '0 && !irq_pending_o));

  a_r11_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i > ADDR_W'(6)) |=> (rdata_o == '0));

endmodule

bind irq_cause_bank icb_checker #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_icb_checker (
  .clk           (clk),
  .rst           (rst),
  .evt_i         (evt_i),
  .wr_en_i       (wr_en_i),
  .rd_en_i       (rd_en_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .irq_pending_o (irq_pending_o),
  .cause_q       (cause_q),
  .mask_q        (mask_q),
  .mode_q        (mode_q)
);

// File: tb/irq_cause_bank_bench.sv
`timescale 1ns/1ps
module irq_cause_bank_bench;

  localparam int W  = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  evt = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          pend;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  irq_cause_bank #(.WIDTH(W), .ADDR_W(AW)) u_irq_cause_bank (
    .clk           (clk),
    .rst           (rst),
    .evt_i         (evt),
    .wr_en_i       (wr_en),
    .rd_en_i       (rd_en),
    .addr_i        (addr),
    .wdata_i       (wdata),
    .rdata_o       (rdata),
    .irq_pending_o (pend)
  );

  typedef struct packed {
    logic          wr;
    logic          rd;
    logic [3:0]    adr;
    logic [31:0]   wd;
    logic [31:0]   ev;
    logic          chk;
    logic [31:0]   exp;
    logic          pend;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 33;
  // wr rd adr wdata evt chk exp_rdata exp_pend req
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,4'd4,32'h0,32'h0,1'b1,32'hFFFF_FFFF,1'b0,8'd10}, // R10 mask all ones
    '{1'b0,1'b1,4'd0,32'h0,32'h0,1'b1,32'h0,1'b0,8'd10},         // R10 cause zero
    '{1'b0,1'b1,4'd6,32'h0,32'h0,1'b1,32'h0,1'b0,8'd10},         // R10 mode zero
    '{1'b0,1'b0,4'd0,32'h0,32'h11,1'b0,32'h0,1'b0,8'd1},         // R1 masked events
    '{1'b0,1'b1,4'd0,32'h0,32'h0,1'b1,32'h11,1'b0,8'd1},         // R1 latched anyway
    '{1'b0,1'b1,4'd5,32'h0,32'h0,1'b1,32'h0,1'b0,8'd12},         // R12 masked view
    '{1'b1,1'b0,4'd3,32'h1,32'h0,1'b0,32'h0,1'b1,8'd4},          // R4 unmask bit0
    '{1'b0,1'b1,4'd4,32'h0,32'h0,1'b1,32'hFFFF_FFFE,1'b1,8'd4},  // R4 mask view
    '{1'b0,1'b1,4'd5,32'h0,32'h0,1'b1,32'h1,1'b1,8'd12},         // R12 masked view
    '{1'b1,1'b0,4'd0,32'h1,32'h0,1'b0,32'h0,1'b0,8'd6},          // R6 w1c bit0
    '{1'b0,1'b1,4'd0,32'h0,32'h0,1'b1,32'h10,1'b0,8'd6},         // R6 only bit0 gone
    '{1'b1,1'b0,4'd2,32'hFFFF_FFFF,32'h0,1'b0,32'h0,1'b0,8'd3},  // R3 mask all
    '{1'b1,1'b0,4'd3,32'h10,32'h0,1'b0,32'h0,1'b1,8'd4},         // R4 unmask bit4
    '{1'b1,1'b0,4'd1,32'h8000_0000,32'h0,1'b0,32'h0,1'b1,8'd5},  // R5 force bit31
    '{1'b0,1'b1,4'd0,32'h0,32'h0,1'b1,32'h8000_0010,1'b1,8'd5},  // R5 readback
    '{1'b1,1'b0,4'd6,32'h8000_0000,32'h0,1'b0,32'h0,1'b1,8'd8},  // R8 bit31 COR
    '{1'b0,1'b1,4'd6,32'h0,32'h0,1'b1,32'h8000_0000,1'b1,8'd8},  // R8 readback
    '{1'b1,1'b0,4'd0,32'h8000_0010,32'h0,1'b0,32'h0,1'b0,8'd6},  // R6 COR bit ignores write
    '{1'b0,1'b1,4'd0,32'h0,32'h0,1'b1,32'h8000_0000,1'b0,8'd7},  // R7 read clears COR bit
    '{1'b0,1'b1,4'd0,32'h0,32'h0,1'b1,32'h0,1'b0,8'd7},          // R7 now zero
    '{1'b1,1'b0,4'd4,32'h0,32'h0,1'b0,32'h0,1'b0,8'd12},         // R12 write to view
    '{1'b0,1'b1,4'd4,32'h0,32'h0,1'b1,32'hFFFF_FFEF,1'b0,8'd12}, // R12 mask unchanged
    '{1'b1,1'b0,4'd1,32'h10,32'h0,1'b0,32'h0,1'b1,8'd5},         // R5 force bit4
    '{1'b1,1'b0,4'd0,32'h10,32'h10,1'b0,32'h0,1'b1,8'd9},        // R9 event vs w1c
    '{1'b0,1'b1,4'd0,32'h0,32'h0,1'b1,32'h10,1'b1,8'd9},         // R9 survives
    '{1'b1,1'b0,4'd6,32'h8000_0010,32'h0,1'b0,32'h0,1'b1,8'd8},  // R8 bit4 COR
    '{1'b0,1'b1,4'd0,32'h0,32'h10,1'b1,32'h10,1'b1,8'd9},        // R9 event vs read
    '{1'b0,1'b1,4'd0,32'h0,32'h0,1'b1,32'h10,1'b0,8'd7},         // R7 cleared now
    '{1'b1,1'b0,4'd1,32'h20,32'h0,1'b0,32'h0,1'b0,8'd5},         // R5 force bit5 masked
    '{1'b0,1'b1,4'd7,32'h0,32'h0,1'b1,32'h0,1'b0,8'd11},         // R11 unused
    '{1'b0,1'b1,4'd15,32'h0,32'h0,1'b1,32'h0,1'b0,8'd11},        // R11 unused
    '{1'b0,1'b1,4'd0,32'h0,32'h0,1'b1,32'h20,1'b0,8'd11},        // R11 no side effect
    '{1'b0,1'b1,4'd0,32'h0,32'h0,1'b1,32'h20,1'b0,8'd7}          // R7 W1C bit kept by read
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic cycle(input logic w, input logic r, input logic [3:0] a,
                       input logic [31:0] d, input logic [31:0] e);
    wr_en = w; rd_en = r; addr = a; wdata = d; evt = e;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; evt = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      cycle(TBL[i].wr, TBL[i].rd, TBL[i].adr, TBL[i].wd, TBL[i].ev);
      if (TBL[i].chk) check($sformatf("R%0d rdata row %0d", TBL[i].req, i), rdata, TBL[i].exp);
      check($sformatf("R2 pending row %0d", i), {31'b0, pend}, {31'b0, TBL[i].pend});
    end

    // R10: reset mid-run with an unmasked pending cause
    cycle(1'b1, 1'b0, 4'd3, 32'h20, 32'h0);
    check("R2 pending before reset", {31'b0, pend}, 32'h1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10 pending in reset", {31'b0, pend}, 32'h0);
    rst = 1'b0;
    cycle(1'b0, 1'b1, 4'd4, 32'h0, 32'h0);
    check("R10 mask after reset", rdata, 32'hFFFF_FFFF);
    cycle(1'b0, 1'b1, 4'd0, 32'h0, 32'h0);
    check("R10 cause after reset", rdata, 32'h0);
    cycle(1'b0, 1'b1, 4'd6, 32'h0, 32'h0);
    check("R10 mode after reset", rdata, 32'h0);

    // R1: event pulse on unmasked bit raises pending
    cycle(1'b1, 1'b0, 4'd3, 32'h4, 32'h0);
    cycle(1'b0, 1'b0, 4'd0, 32'h0, 32'h4);
    check("R1 pending from event", {31'b0, pend}, 32'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule